// File: doc/BRIEF.md
# Parallel Camera Capture with Sync-Line Blanking

This block sits behind a parallel camera port and sorts the incoming byte stream into accepted pixels and blanking. Each pixel clock brings an 8-bit data word together with a horizontal and a vertical sync level. A byte is forwarded only when both syncs are inactive and a frame is open. The polarity of each sync line is chosen by a configuration input. The syncs are normalised and registered once. Every accepted byte then appears on `pix_o` with `pix_valid_o`, one clock after it was sampled. Two markers travel with it: one flags the first byte of a frame, the other the first byte of each line.

Capture is armed by a rising edge on `cap_en_i`. An armed block forwards nothing until the vertical sync next goes from active to inactive, which opens a frame. When the vertical sync turns active again after a frame that delivered data, `eof_o` pulses for one clock so that a downstream buffer manager can switch buffers. In continuous mode the block re-arms by itself and takes frame after frame. In snapshot mode it drops its armed state after one frame. Lowering `cap_en_i` lets the current frame run to its end and starts no new one.

The controller has three states. IDLE moves to ARMED when the enable latch is set. ARMED moves back to IDLE when the latch clears, and moves to ACTIVE on a vertical-sync deactivation. ACTIVE stays put until the vertical sync activates. At that point it moves to ARMED if the latch is set and the mode is continuous, or if the frame was empty. Otherwise it moves to IDLE, and in snapshot mode after a non-empty frame the latch clears.

Top module: `cam_sync_capture`

## Requirements
- R1: After reset `pix_valid_o`, `frame_start_o`, `line_start_o`, `eof_o` and `armed_o` are all 0.
- R2: A byte sampled while the horizontal sync is active never produces `pix_valid_o`.
- R3: A byte sampled while the vertical sync is active never produces `pix_valid_o`.
- R4: After a rising edge of `cap_en_i`, `armed_o` goes to 1. No byte is forwarded until the next active-to-inactive transition of the vertical sync, so the rest of a frame already in progress is dropped.
- R5: An accepted byte sampled at a clock edge appears unchanged on `pix_o` with `pix_valid_o` high during the following clock cycle.
- R6: `hs_act_high_i`/`vs_act_high_i` = 1 makes a high level on `hsync_i`/`vsync_i` the active (blanking) level; 0 makes a low level the active level.
- R7: `eof_o` is high for exactly one cycle, in the cycle after the edge that first samples the vertical sync active following a frame in which at least one byte was accepted.
- R8: With `cont_mode_i` = 1 and the enable held, every following frame is captured with no new enable edge, and each one raises its own `eof_o`.
- R9: With `cont_mode_i` = 0, after one frame that delivered data, `armed_o` returns to 0 and later frames are not forwarded.
- R10: If `cap_en_i` falls in the middle of a captured frame, the rest of that frame is still forwarded and its `eof_o` still fires. `armed_o` is then 0 and the next frame is not forwarded.
- R11: `frame_start_o` is 1 only on the first accepted byte of a frame. `line_start_o` is 1 only on the first accepted byte after a horizontal or vertical blanking interval, so both are 1 on the first byte of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock; all sampling on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_en_i | input | 1 | Capture enable; rising edge arms, low level disarms |
| cont_mode_i | input | 1 | 1 = continuous frames, 0 = single snapshot |
| hs_act_high_i | input | 1 | 1 = horizontal sync active high |
| vs_act_high_i | input | 1 | 1 = vertical sync active high |
| pix_i | input | 8 | Camera data bus |
| hsync_i | input | 1 | Horizontal sync from camera |
| vsync_i | input | 1 | Vertical sync from camera |
| pix_o | output | 8 | Accepted data byte |
| pix_valid_o | output | 1 | `pix_o` holds an accepted byte |
| frame_start_o | output | 1 | First accepted byte of a frame |
| line_start_o | output | 1 | First accepted byte of a line |
| eof_o | output | 1 | One-cycle end-of-frame pulse |
| armed_o | output | 1 | Enable latch state |

## Verification
The first accepted byte of every frame carries both `frame_start_o` and `line_start_o` in the same cycle. Every frame the bench sends opens with a full line right after the vertical blanking, so this coincidence comes up in each scenario, and the scoreboard compares both flags on every popped byte. The end-of-frame pulse and the snapshot disarm also land on adjacent cycles. These are judged by counting pulses against frames and sampling `armed_o` after the vertical blanking.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ACTIVE = 2'd2
    } cap_state_e;
endpackage

// File: rtl/cam_sync_norm.sv
// Registers the camera pins and maps each sync onto an active-high blank flag.
module cam_sync_norm #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] pix_i,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              hs_act_high_i,
    input  logic              vs_act_high_i,
    output logic [DATA_W-1:0] pix_q_o,
    output logic              hs_blank_o,
    output logic              vs_blank_o,
    output logic              vs_blank_prev_o
);
    logic hs_blank_raw;
    logic vs_blank_raw;

    assign hs_blank_raw = ~(hsync_i ^ hs_act_high_i);
    assign vs_blank_raw = ~(vsync_i ^ vs_act_high_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pix_q_o         <= '0;
            hs_blank_o      <= 1'b0;
            vs_blank_o      <= 1'b0;
            vs_blank_prev_o <= 1'b0;
        end else begin
            pix_q_o         <= pix_i;
            hs_blank_o      <= hs_blank_raw;
            vs_blank_o      <= vs_blank_raw;
            vs_blank_prev_o <= vs_blank_o;
        end
    end
endmodule

// File: rtl/cam_en_ctrl.sv
// Enable latch: set by a rising enable, cleared by a low enable or a snapshot finish.
module cam_en_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cap_en_i,
    input  logic snap_clr_i,
    output logic en_o
);
    logic en_d;
    logic en_rise;

    assign en_rise = cap_en_i & ~en_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_d <= 1'b0;
            en_o <= 1'b0;
        end else begin
            en_d <= cap_en_i;
            if (en_rise)
                en_o <= 1'b1;
            else if (!cap_en_i || snap_clr_i)
                en_o <= 1'b0;
        end
    end
endmodule

// File: rtl/cam_capture_fsm.sv
module cam_capture_fsm
    import cam_cap_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic cont_mode_i,
    input  logic hs_blank_i,
    input  logic vs_blank_i,
    input  logic vs_blank_prev_i,
    output logic snap_clr_o,
    output logic valid_o,
    output logic frame_start_o,
    output logic line_start_o,
    output logic eof_o
);
    cap_state_e state_q, state_d;
    logic       got_q;
    logic       line_open_q;
    logic       vs_fall;
    logic       vs_rise;
    logic       frame_on;

    assign vs_fall = vs_blank_prev_i & ~vs_blank_i;
    assign vs_rise = vs_blank_i & ~vs_blank_prev_i;

    // Next-state process
    always_comb begin
        state_d    = state_q;
        snap_clr_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i)
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!en_i)
                    state_d = ST_IDLE;
                else if (vs_fall)
                    state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (vs_rise) begin
                    state_d    = (en_i && (cont_mode_i || !got_q)) ? ST_ARMED : ST_IDLE;
                    snap_clr_o = got_q && !cont_mode_i;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        frame_on      = (state_q == ST_ACTIVE) ||
                        (state_q == ST_ARMED && en_i && vs_fall);
        valid_o       = frame_on && !hs_blank_i && !vs_blank_i;
        frame_start_o = valid_o && !got_q;
        line_start_o  = valid_o && !line_open_q;
        eof_o         = (state_q == ST_ACTIVE) && vs_rise && got_q;
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q     <= ST_IDLE;
            got_q       <= 1'b0;
            line_open_q <= 1'b0;
        end else begin
            state_q <= state_d;
            got_q   <= (state_d == ST_ACTIVE) ? (got_q | valid_o) : 1'b0;
            if (valid_o)
                line_open_q <= 1'b1;
            else if (hs_blank_i || vs_blank_i)
                line_open_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cam_sync_capture.sv
module cam_sync_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cap_en_i,
    input  logic              cont_mode_i,
    input  logic              hs_act_high_i,
    input  logic              vs_act_high_i,
    input  logic [DATA_W-1:0] pix_i,
    input  logic              hsync_i,
    input  logic              vsync_i,
    output logic [DATA_W-1:0] pix_o,
    output logic              pix_valid_o,
    output logic              frame_start_o,
    output logic              line_start_o,
    output logic              eof_o,
    output logic              armed_o
);
    logic hs_blank;
    logic vs_blank;
    logic vs_blank_prev;
    logic snap_clr;
    logic en;

    cam_sync_norm #(.DATA_W(DATA_W)) norm_i (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .pix_i           (pix_i),
        .hsync_i         (hsync_i),
        .vsync_i         (vsync_i),
        .hs_act_high_i   (hs_act_high_i),
        .vs_act_high_i   (vs_act_high_i),
        .pix_q_o         (pix_o),
        .hs_blank_o      (hs_blank),
        .vs_blank_o      (vs_blank),
        .vs_blank_prev_o (vs_blank_prev)
    );

    cam_en_ctrl en_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cap_en_i   (cap_en_i),
        .snap_clr_i (snap_clr),
        .en_o       (en)
    );

    cam_capture_fsm fsm_i (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .en_i            (en),
        .cont_mode_i     (cont_mode_i),
        .hs_blank_i      (hs_blank),
        .vs_blank_i      (vs_blank),
        .vs_blank_prev_i (vs_blank_prev),
        .snap_clr_o      (snap_clr),
        .valid_o         (pix_valid_o),
        .frame_start_o   (frame_start_o),
        .line_start_o    (line_start_o),
        .eof_o           (eof_o)
    );

    assign armed_o = en;
endmodule

// File: rtl/cam_sync_capture_chk.sv
module cam_sync_capture_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cap_en_i,
    input logic              cont_mode_i,
    input logic              hs_act_high_i,
    input logic              vs_act_high_i,
    input logic [DATA_W-1:0] pix_i,
    input logic              hsync_i,
    input logic              vsync_i,
    input logic [DATA_W-1:0] pix_o,
    input logic              pix_valid_o,
    input logic              frame_start_o,
    input logic              line_start_o,
    input logic              eof_o,
    input logic              armed_o
);
    a_r2_hs_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_valid_o |-> ($past(hsync_i) != $past(hs_act_high_i)));

    a_r3_vs_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_valid_o |-> ($past(vsync_i) != $past(vs_act_high_i)));

    a_r5_data_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_valid_o |-> (pix_o == $past(pix_i)));

    a_r7_eof_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eof_o |=> !eof_o);

    a_r9_snap_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eof_o && !cont_mode_i && !(cap_en_i && !$past(cap_en_i))) |=> !armed_o);

    a_r11_frame_marks_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |-> (line_start_o && pix_valid_o));
endmodule

bind cam_sync_capture cam_sync_capture_chk #(.DATA_W(DATA_W)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cap_en_i      (cap_en_i),
    .cont_mode_i   (cont_mode_i),
    .hs_act_high_i (hs_act_high_i),
    .vs_act_high_i (vs_act_high_i),
    .pix_i         (pix_i),
    .hsync_i       (hsync_i),
    .vsync_i       (vsync_i),
    .pix_o         (pix_o),
    .pix_valid_o   (pix_valid_o),
    .frame_start_o (frame_start_o),
    .line_start_o  (line_start_o),
    .eof_o         (eof_o),
    .armed_o       (armed_o)
);

// File: tb/cam_sync_capture_tb_top.sv
`timescale 1ns/1ps
module cam_sync_capture_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_en = 1'b0;
    logic       cont = 1'b1;
    logic       hs_pol = 1'b1;
    logic       vs_pol = 1'b1;
    logic [7:0] pix = 8'h00;
    logic       hsync = 1'b0;
    logic       vsync = 1'b0;
    logic [7:0] pix_o;
    logic       valid_o, fs_o, ls_o, eof_o, armed_o;

    int checks = 0;
    int fails = 0;
    int exp_eof = 0;
    int obs_eof = 0;
    int obs_valid = 0;
    bit pending_eof = 0;
    bit eof_prev = 0;
    logic [7:0] seed = 8'h10;
    logic [9:0] sb_q[$];

    always #4 clk = ~clk;

    cam_sync_capture dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cap_en_i(cap_en), .cont_mode_i(cont),
        .hs_act_high_i(hs_pol), .vs_act_high_i(vs_pol), .pix_i(pix),
        .hsync_i(hsync), .vsync_i(vsync), .pix_o(pix_o), .pix_valid_o(valid_o),
        .frame_start_o(fs_o), .line_start_o(ls_o), .eof_o(eof_o), .armed_o(armed_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One pixel clock of stimulus, blanking given as logical activity (R6 polarity mapping)
    task automatic drive(input logic [7:0] d, input bit hs, input bit vs);
        @(negedge clk);
        pix   = d;
        hsync = hs ? hs_pol : ~hs_pol;
        vsync = vs ? vs_pol : ~vs_pol;
    endtask

    task automatic vs_blank(input int n);
        if (pending_eof) begin
            exp_eof++;
            pending_eof = 0;
        end
        for (int i = 0; i < n; i++)
            drive(8'hF0 + 8'(i), i[0], 1'b1);
    endtask

    task automatic send_frame(input int nl, input int np, input bit exp, input int dis_line);
        bit first = 1;
        vs_blank(4);
        for (int l = 0; l < nl; l++) begin
            if (l == dis_line) cap_en = 1'b0;
            for (int p = 0; p < np; p++) begin
                drive(seed, 1'b0, 1'b0);
                if (exp) sb_q.push_back({first, (p == 0), seed});
                first = 0;
                seed  = seed + 8'd7;
            end
            drive(8'hE0 + 8'(l), 1'b1, 1'b0);
            drive(8'hE8 + 8'(l), 1'b1, 1'b0);
        end
        pending_eof = exp;
    endtask

    // Monitor: scoreboard pop and eof pulse-width check
    always @(negedge clk) begin
        if (rst_n) begin
            if (eof_o) begin
                obs_eof++;
                check(!eof_prev, "R7 eof width", 1, 0);
            end
            eof_prev = eof_o;
            if (valid_o) begin
                obs_valid++;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2/R3/R4 unexpected byte", int'(pix_o), -1);
                end else begin
                    logic [9:0] e;
                    e = sb_q.pop_front();
                    check(pix_o == e[7:0], "R5 data", int'(pix_o), int'(e[7:0]));
                    check(fs_o == e[9], "R11 frame_start", int'(fs_o), int'(e[9]));
                    check(ls_o == e[8], "R11 line_start", int'(ls_o), int'(e[8]));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) drive(8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(valid_o == 0, "R1 valid", int'(valid_o), 0);
        check(eof_o == 0, "R1 eof", int'(eof_o), 0);
        check(armed_o == 0, "R1 armed", int'(armed_o), 0);
        check(fs_o == 0 && ls_o == 0, "R1 markers", int'({fs_o, ls_o}), 0);

        // R4: enable mid-frame, bytes in progress ignored
        repeat (3) drive(8'h55, 1'b0, 1'b0);
        cap_en = 1'b1;
        for (int i = 0; i < 6; i++) drive(8'h60 + 8'(i), 1'b0, 1'b0);
        @(negedge clk);
        check(obs_valid == 0, "R4 no early data", obs_valid, 0);
        check(armed_o == 1, "R4 armed", int'(armed_o), 1);

        // R8 continuous, R2/R3 blanking junk inside frames
        send_frame(3, 5, 1, -1);
        send_frame(2, 4, 1, -1);
        vs_blank(4);
        check(obs_eof == exp_eof && exp_eof == 2, "R8 eof per frame", obs_eof, 2);

        // R9 snapshot
        cap_en = 1'b0;
        vs_blank(2);
        cont = 1'b0;
        cap_en = 1'b1;
        send_frame(2, 6, 1, -1);
        send_frame(2, 3, 0, -1);
        vs_blank(4);
        check(armed_o == 0, "R9 snapshot disarm", int'(armed_o), 0);
        check(obs_eof == exp_eof, "R9 eof", obs_eof, exp_eof);

        // R10 disable in mid frame
        cap_en = 1'b0;
        vs_blank(2);
        cap_en = 1'b1;
        cont = 1'b1;
        send_frame(3, 4, 1, 1);
        send_frame(2, 3, 0, -1);
        vs_blank(4);
        check(armed_o == 0, "R10 disarmed after frame", int'(armed_o), 0);
        check(obs_eof == exp_eof, "R10 eof", obs_eof, exp_eof);

        // R6 active-low syncs
        hs_pol = 1'b0;
        vs_pol = 1'b0;
        vs_blank(3);
        cap_en = 1'b1;
        send_frame(2, 5, 1, -1);
        vs_blank(4);
        @(negedge clk);
        check(obs_eof == exp_eof && exp_eof == 5, "R6/R7 eof count", obs_eof, 5);
        check(sb_q.size() == 0, "R5/R6 all bytes delivered", sb_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule